// File: doc/BRIEF.md
# Ramp and Tracking Converter Controller

This block is the digital half of a converter that is built around an external DAC and a single comparator. It drives the DAC with a code, reads back one bit that says whether the analog input lies above the DAC output, and turns that feedback into a digital result. Software or a neighbouring block picks one of two modes at run time.

In ramp mode a request starts one conversion. The code restarts at zero and climbs one step per clock while the comparator reports the input above the DAC. The first code at which it stops doing so is captured as the result, and a one-cycle done pulse marks it. If the comparator never stops, the conversion ends at full scale. In tracking mode there are no requests. The code steps up or down by one on every clock to follow the input. It saturates at both ends of the range, and a valid strobe accompanies every new code.

Top module: `ramp_track_adc_ctl`

## Requirements
- R1: While reset is held and in the first cycle after it, dac_code_o, result_o, done_o, valid_o and busy_o are all zero, and the block is in ramp mode.
- R2: In ramp mode, when idle, a high start_i begins a conversion: busy_o rises and dac_code_o is 0 after that edge, then dac_code_o rises by one per clock while cmp_above_i is high.
- R3: A ramp conversion ends at the first edge where cmp_above_i is low: result_o takes the current code, done_o is high for exactly one cycle, and busy_o falls. For an integer input level v below full scale, done_o is seen v+1 edges after the start edge with result_o = v.
- R4: If the code reaches 2^CODE_W-1 with cmp_above_i still high, the conversion ends on the next edge with result_o = 2^CODE_W-1 (256 edges after start for the default width).
- R5: start_i while a conversion is running is ignored. The running conversion keeps its result and its timing.
- R6: In tracking mode each edge moves the code up by one when cmp_above_i is high and down by one otherwise. It holds at 2^CODE_W-1 on an up step and at 0 on a down step, and never wraps.
- R7: In tracking mode valid_o is high on every cycle after the first tracking step, result_o equals dac_code_o, and done_o stays low. In ramp mode valid_o is low.
- R8: mode_track_i (1 = tracking, 0 = ramp) is taken on the next edge only when no conversion is running. During a conversion the request waits until the edge after the done edge. A start_i in the same cycle as a tracking request is ignored.
- R9: On the edge that switches from tracking to ramp, dac_code_o is cleared to 0, valid_o falls, and result_o keeps its last value.
- R10: In ramp mode result_o holds its value between conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_track_i | input | 1 | Mode request: 1 tracking, 0 ramp |
| start_i | input | 1 | Begin a ramp conversion |
| cmp_above_i | input | 1 | Comparator: analog input above DAC output |
| dac_code_o | output | CODE_W | Code driven to the external DAC |
| busy_o | output | 1 | Ramp conversion in progress |
| result_o | output | CODE_W | Converted value |
| done_o | output | 1 | One-cycle pulse at the end of a ramp conversion |
| valid_o | output | 1 | Tracking code updated this cycle |

## Verification
A ramp conversion of level v shows done_o and its result v+1 edges after the edge that took start_i, or 256 edges at full scale. The bench counts negedges from the start edge and requires the pulse at exactly that count. A tracking code is due one edge after the comparator value that produced it, so the bench predicts each code from the previous code it sampled. A mode request shows its first tracking step two edges after it is taken, and the switch back to ramp clears the code one edge after the request. The bench samples only at negedges, after the edge the requirement names.

// File: rtl/rta_pkg.sv
package rta_pkg;

    typedef enum logic {
        MODE_RAMP  = 1'b0,
        MODE_TRACK = 1'b1
    } conv_mode_e;

endpackage

// File: rtl/rta_step.sv
// Saturating one-step arithmetic shared by the ramp and tracking paths.
module rta_step #(
    parameter int CODE_W = 8
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              up_i,
    output logic [CODE_W-1:0] inc_code_o,
    output logic [CODE_W-1:0] trk_code_o,
    output logic              at_max_o,
    output logic              at_zero_o
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] CODE_ONE = CODE_W'(1);

    always_comb begin
        at_max_o   = (code_i == CODE_MAX);
        at_zero_o  = (code_i == '0);
        inc_code_o = at_max_o ? CODE_MAX : code_i + CODE_ONE;
        if (up_i) begin
            trk_code_o = inc_code_o;
        end else begin
            trk_code_o = at_zero_o ? '0 : code_i - CODE_ONE;
        end
    end
endmodule

// File: rtl/rta_mode_sel.sv
// Decides the mode for the next cycle; requests wait while a ramp runs.
module rta_mode_sel
    import rta_pkg::*;
(
    input  conv_mode_e mode_q_i,
    input  logic       mode_req_i,
    input  logic       busy_i,
    output conv_mode_e mode_d_o,
    output logic       enter_ramp_o
);
    always_comb begin
        if (busy_i) begin
            mode_d_o = mode_q_i;
        end else begin
            mode_d_o = mode_req_i ? MODE_TRACK : MODE_RAMP;
        end
        enter_ramp_o = (mode_q_i == MODE_TRACK) && (mode_d_o == MODE_RAMP);
    end
endmodule

// File: rtl/ramp_track_adc_ctl.sv
module ramp_track_adc_ctl
    import rta_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_track_i,
    input  logic              start_i,
    input  logic              cmp_above_i,
    output logic [CODE_W-1:0] dac_code_o,
    output logic              busy_o,
    output logic [CODE_W-1:0] result_o,
    output logic              done_o,
    output logic              valid_o
);
    typedef struct packed {
        conv_mode_e        mode;
        logic [CODE_W-1:0] code;
        logic              busy;
        logic [CODE_W-1:0] result;
        logic              done;
        logic              valid;
    } state_t;

    localparam state_t STATE_RST = '{
        mode:   MODE_RAMP,
        code:   '0,
        busy:   1'b0,
        result: '0,
        done:   1'b0,
        valid:  1'b0
    };

    state_t s_q, s_d;

    logic [CODE_W-1:0] inc_code, trk_code;
    logic              at_max, at_zero;
    conv_mode_e        mode_nxt;
    logic              enter_ramp;
    conv_mode_e        mode_cur;

    rta_step #(.CODE_W(CODE_W)) step_i (
        .code_i     (s_q.code),
        .up_i       (cmp_above_i),
        .inc_code_o (inc_code),
        .trk_code_o (trk_code),
        .at_max_o   (at_max),
        .at_zero_o  (at_zero)
    );

    rta_mode_sel mode_i (
        .mode_q_i     (s_q.mode),
        .mode_req_i   (mode_track_i),
        .busy_i       (s_q.busy),
        .mode_d_o     (mode_nxt),
        .enter_ramp_o (enter_ramp)
    );

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        s_d.valid = 1'b0;
        s_d.mode  = mode_nxt;
        if (enter_ramp) begin
            s_d.code = '0;
        end else if (s_q.mode == MODE_TRACK) begin
            s_d.code   = trk_code;
            s_d.result = trk_code;
            s_d.valid  = 1'b1;
        end else if (s_q.busy) begin
            if (cmp_above_i && !at_max) begin
                s_d.code = inc_code;
            end else begin
                s_d.busy   = 1'b0;
                s_d.done   = 1'b1;
                s_d.result = s_q.code;
            end
        end else if (start_i && mode_nxt == MODE_RAMP) begin
            s_d.busy = 1'b1;
            s_d.code = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= STATE_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign mode_cur   = s_q.mode;
    assign dac_code_o = s_q.code;
    assign busy_o     = s_q.busy;
    assign result_o   = s_q.result;
    assign done_o     = s_q.done;
    assign valid_o    = s_q.valid;

    logic unused_zero;
    assign unused_zero = at_zero;
endmodule

// File: rtl/rta_checker.sv
module rta_checker
    import rta_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] dac_code,
    input logic              busy,
    input logic [CODE_W-1:0] result,
    input logic              done,
    input logic              valid,
    input conv_mode_e        mode_q
);
    p_start_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> dac_code == '0);

    p_ramp_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> int'(dac_code) == int'($past(dac_code)) + 1);

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_ends_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done && result == dac_code);

    p_track_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (int'(dac_code) - int'($past(dac_code))) inside {-1, 0, 1});

    p_no_done_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> !done && result == dac_code);

    p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(mode_q));

    p_ramp_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_RAMP && $past(mode_q) == MODE_TRACK) |-> dac_code == '0 && !valid);

    p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !valid) |-> $stable(result));
endmodule

bind ramp_track_adc_ctl rta_checker #(.CODE_W(CODE_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .dac_code (dac_code_o),
    .busy     (busy_o),
    .result   (result_o),
    .done     (done_o),
    .valid    (valid_o),
    .mode_q   (mode_cur)
);

// File: tb/ramp_track_adc_ctl_tb_top.sv
module ramp_track_adc_ctl_tb_top;
    localparam int CODE_W = 8;
    localparam int MAXC   = (1 << CODE_W) - 1;
    localparam int NVEC   = 7;
    localparam int VEC_VIN [NVEC] = '{0, 1, 5, 37, 128, 255, 300};
    localparam int VEC_RES [NVEC] = '{0, 1, 5, 37, 128, 255, 255};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_track = 1'b0;
    logic start = 1'b0;
    logic cmp_above;
    logic [CODE_W-1:0] dac_code, result;
    logic busy, done, valid;
    int vin = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    // ideal DAC plus comparator, input level in LSB units
    assign cmp_above = (vin > int'(dac_code));

    ramp_track_adc_ctl #(.CODE_W(CODE_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_track_i (mode_track),
        .start_i      (start),
        .cmp_above_i  (cmp_above),
        .dac_code_o   (dac_code),
        .busy_o       (busy),
        .result_o     (result),
        .done_o       (done),
        .valid_o      (valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // runs one ramp conversion, optionally pulsing start again mid-way (R5)
    task automatic ramp(input int level, input int exp_res, input bit restart);
        int cyc = 0;
        @(negedge clk);
        vin = level;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && dac_code == 0, "R2 start", int'(dac_code), 0);
        while (!done && cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (restart && cyc == 2) start = 1'b1;
            if (restart && cyc == 3) start = 1'b0;
        end
        check(cyc == exp_res + 1, exp_res == MAXC ? "R4 cycles" : "R3 cycles", cyc, exp_res + 1);
        check(int'(result) == exp_res, exp_res == MAXC ? "R4 result" : "R3 result", int'(result), exp_res);
        check(!busy, "R3 busy", int'(busy), 0);
        @(negedge clk);
        check(!done, "R3 pulse", int'(done), 0);
        check(int'(result) == exp_res, "R10 hold", int'(result), exp_res);
    endtask

    task automatic track(input int level, input int steps);
        int prev;
        int exp;
        vin = level;
        for (int i = 0; i < steps; i++) begin
            prev = int'(dac_code);
            @(negedge clk);
            if (vin > prev) exp = (prev == MAXC) ? MAXC : prev + 1;
            else            exp = (prev == 0) ? 0 : prev - 1;
            check(int'(dac_code) == exp, "R6 step", int'(dac_code), exp);
            check(valid && !done && result == dac_code, "R7 strobe", int'(valid), 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(dac_code == 0 && result == 0 && !done && !valid && !busy, "R1 reset", int'(dac_code), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dac_code == 0 && !busy && !valid, "R1 after reset", int'(busy), 0);

        for (int k = 0; k < NVEC; k++) ramp(VEC_VIN[k], VEC_RES[k], 1'b0);

        // R5: extra start during a running conversion
        ramp(60, 60, 1'b1);
        repeat (5) @(negedge clk);
        check(result == 60 && !busy, "R10 idle hold", int'(result), 60);

        // R8: tracking request made during a conversion waits
        @(negedge clk);
        vin = 50;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        mode_track = 1'b1;
        for (int c = 1; c <= 51; c++) begin
            if (done) break;
            check(!valid, "R8 deferred", int'(valid), 0);
            @(negedge clk);
        end
        check(done && result == 50, "R8 conversion kept", int'(result), 50);
        @(negedge clk);
        check(!valid, "R8 mode edge", int'(valid), 0);
        @(negedge clk);
        check(valid, "R7 first step", int'(valid), 1);

        track(80, 40);
        track(300, 260);
        check(int'(dac_code) == MAXC, "R6 top clamp", int'(dac_code), MAXC);
        track(0, 260);
        check(dac_code == 0, "R6 bottom clamp", int'(dac_code), 0);
        track(100, 110);

        // R9: back to ramp clears the code, result kept
        @(negedge clk);
        mode_track = 1'b0;
        @(negedge clk);
        check(dac_code == 0 && !valid, "R9 clear", int'(dac_code), 0);
        check(!done, "R7 no done", int'(done), 0);

        // R8: start together with a tracking request is ignored
        @(negedge clk);
        mode_track = 1'b1;
        start = 1'b1;
        vin = 20;
        @(negedge clk);
        start = 1'b0;
        check(!busy, "R8 start ignored", int'(busy), 0);
        mode_track = 1'b0;
        repeat (3) @(negedge clk);
        ramp(20, 20, 1'b0);

        summary();
    end
endmodule